// File: doc/BRIEF.md
# Sensor Timing Serial Control Register

This block is the three-wire control port of an image sensor timing generator. A host shifts in a 48-bit control word on a serial data line. Each bit is qualified by a serial clock, and the whole word is framed by an active-low enable. The first eight bits received form a category code, and that code decides which set of fields the word carries. A shutter word carries a clock-timing select and three exposure counts. A general word carries the drive mode, the pattern mode, the optical-black pattern, the converter clock phase and the standby mode.

Decoded fields first go into shadow registers. They move to the active outputs only at update points, and each field group has its own point. The standby field takes effect as soon as the enable returns high. The drive and pattern modes wait for a falling edge of vertical sync. Every other field waits for a falling edge of horizontal sync that falls inside a readout line. The downstream pulse generators read the active outputs. The serial clock, data and enable are asynchronous and pass through two-flop synchronizers. The sync inputs and the readout-line flag are synchronous to the system clock.

Top module: `sensor_tg_serial_ctrl`

## Requirements
- R1: While `rst_n` is low, every active output and every shadow field is zero, and `cam_normal` is 1. A sync commit that follows a reset therefore moves zeros to the active outputs.
- R2: A bit is taken on each rising edge of `ser_clk` while `ser_en_n` is low, and the first bit becomes bit 0 of the word. A frame is accepted only when exactly 48 bits arrive between a fall and a rise of `ser_en_n`. A frame with fewer or more bits changes no shadow or active field.
- R3: The category code sits in bits 7:0, with the first bit received as bit 0. Code 8'h81 marks a shutter word: clock select in bits 9:8, shutter vertical count in bits 19:10, shutter horizontal count in bits 31:20, high-speed vertical count in bits 41:32. Code 8'h00 marks a general word. A word with any other code is ignored.
- R4: The standby field, bits 39:38 of a general word, reaches `act_standby` as soon as `ser_en_n` rises, with no sync event needed.
- R5: The drive mode (general word bits 11:10) and the pattern mode (bits 17:16) reach the outputs only on a falling edge of `vsync_n`.
- R6: The shutter-word fields and the general-word optical-black pattern (bits 35:34) and converter phase (bits 37:36) reach the outputs only on a falling edge of `hsync_n` while `readout_line` is high. A falling edge of `hsync_n` while `readout_line` is low has no effect.
- R7: `cam_normal` is 1 whenever bit 0 of `act_standby` (word bit 38) is 0, whatever the value of bit 1.
- R8: When several words of one category arrive before a commit, the last one is the one committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, first bit is word bit 0 |
| ser_en_n | input | 1 | Active-low frame enable |
| hsync_n | input | 1 | Horizontal sync, active low, synchronous to clk |
| vsync_n | input | 1 | Vertical sync, active low, synchronous to clk |
| readout_line | input | 1 | High during a readout line |
| act_clk_sel | output | 2 | Active clock-timing select |
| act_shut_v | output | 10 | Active shutter vertical count |
| act_shut_h | output | 12 | Active shutter horizontal count |
| act_hs_v | output | 10 | Active high-speed shutter vertical count |
| act_mode | output | 2 | Active basic drive mode |
| act_pattern | output | 2 | Active pattern mode |
| act_ob_pat | output | 2 | Active optical-black pattern |
| act_adc_phase | output | 2 | Active converter clock phase |
| act_standby | output | 2 | Active standby field |
| cam_normal | output | 1 | High when the standby field selects normal operation |

## Verification
The assertions assume that each serial clock level and each enable level lasts at least three system clocks. Under that assumption every edge survives the synchronizers and each rising edge yields exactly one bit. The assertions also assume that the sync inputs and the readout-line flag are already synchronous to the system clock. The bench holds every serial level for four clocks and changes the data only while the serial clock is low. It drives the sync pulses and the readout flag on clock edges, and it keeps each sync edge apart from the cycle in which a frame is accepted.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int WORD_W = 48;
  localparam int CAT_W  = 8;
  localparam logic [CAT_W-1:0] CAT_SHUTTER = 8'h81;
  localparam logic [CAT_W-1:0] CAT_GENERAL = 8'h00;

  typedef struct packed {
    logic [1:0]  clk_sel;
    logic [9:0]  shut_v;
    logic [11:0] shut_h;
    logic [9:0]  hs_v;
  } shut_t;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] pattern;
    logic [1:0] ob_pat;
    logic [1:0] adc_phase;
  } gen_t;

  function automatic logic [CAT_W-1:0] word_cat(input logic [WORD_W-1:0] w);
    return w[CAT_W-1:0];
  endfunction

  function automatic shut_t unpack_shut(input logic [WORD_W-1:0] w);
    shut_t s;
    s.clk_sel = w[9:8];
    s.shut_v  = w[19:10];
    s.shut_h  = w[31:20];
    s.hs_v    = w[41:32];
    return s;
  endfunction

  function automatic gen_t unpack_gen(input logic [WORD_W-1:0] w);
    gen_t g;
    g.mode      = w[11:10];
    g.pattern   = w[17:16];
    g.ob_pat    = w[35:34];
    g.adc_phase = w[37:36];
    return g;
  endfunction

  function automatic logic [1:0] standby_of(input logic [WORD_W-1:0] w);
    return w[39:38];
  endfunction

  function automatic logic frame_complete(input int unsigned count, input int unsigned width);
    return count == width;
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
  parameter int WORD_W = 48,
  localparam int CNT_MAX = WORD_W + 1,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              en_n_s,
  output logic [WORD_W-1:0] word,
  output logic              word_strb,
  output logic              en_rise
);
  logic             sclk_d;
  logic             en_d;
  logic [CNT_W-1:0] cnt;
  logic             sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign en_rise   = en_n_s & ~en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      en_d      <= 1'b1;
      cnt       <= '0;
      word      <= '0;
      word_strb <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      en_d      <= en_n_s;
      word_strb <= 1'b0;
      if (en_n_s) begin
        cnt <= '0;
        if (en_rise)
          word_strb <= scp_pkg::frame_complete(int'(cnt), WORD_W);
      end else if (sclk_rise) begin
        word <= {sdat_s, word[WORD_W-1:1]};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scp_shadow.sv
module scp_shadow
  import scp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word,
  input  logic              word_strb,
  output shut_t             shut_sh,
  output gen_t              gen_sh,
  output logic              stb_load,
  output logic [1:0]        stb_new
);
  logic is_shut;
  logic is_gen;

  assign is_shut  = word_strb && (word_cat(word) == CAT_SHUTTER);
  assign is_gen   = word_strb && (word_cat(word) == CAT_GENERAL);
  assign stb_load = is_gen;
  assign stb_new  = standby_of(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_sh <= '0;
      gen_sh  <= '0;
    end else begin
      if (is_shut) shut_sh <= unpack_shut(word);
      if (is_gen)  gen_sh  <= unpack_gen(word);
    end
  end
endmodule

// File: rtl/scp_commit.sv
module scp_commit
  import scp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_n,
  input  logic       vsync_n,
  input  logic       readout_line,
  input  shut_t      shut_sh,
  input  gen_t       gen_sh,
  input  logic       stb_load,
  input  logic [1:0] stb_new,
  output logic       hs_commit,
  output logic       vs_commit,
  output shut_t      shut_act,
  output gen_t       gen_act,
  output logic [1:0] stb_act
);
  logic hs_d;
  logic vs_d;

  assign hs_commit = hs_d & ~hsync_n & readout_line;
  assign vs_commit = vs_d & ~vsync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_d     <= 1'b1;
      vs_d     <= 1'b1;
      shut_act <= '0;
      gen_act  <= '0;
      stb_act  <= '0;
    end else begin
      hs_d <= hsync_n;
      vs_d <= vsync_n;
      if (hs_commit) begin
        shut_act          <= shut_sh;
        gen_act.ob_pat    <= gen_sh.ob_pat;
        gen_act.adc_phase <= gen_sh.adc_phase;
      end
      if (vs_commit) begin
        gen_act.mode    <= gen_sh.mode;
        gen_act.pattern <= gen_sh.pattern;
      end
      if (stb_load) stb_act <= stb_new;
    end
  end
endmodule

// File: rtl/sensor_tg_serial_ctrl.sv
module sensor_tg_serial_ctrl
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_en_n,
  input  logic        hsync_n,
  input  logic        vsync_n,
  input  logic        readout_line,
  output logic [1:0]  act_clk_sel,
  output logic [9:0]  act_shut_v,
  output logic [11:0] act_shut_h,
  output logic [9:0]  act_hs_v,
  output logic [1:0]  act_mode,
  output logic [1:0]  act_pattern,
  output logic [1:0]  act_ob_pat,
  output logic [1:0]  act_adc_phase,
  output logic [1:0]  act_standby,
  output logic        cam_normal
);
  logic [2:0]        ser_s;
  logic [WORD_W-1:0] word;
  logic              word_strb;
  logic              en_rise;
  logic              hs_commit;
  logic              vs_commit;
  logic              stb_load;
  logic [1:0]        stb_new;
  shut_t             shut_sh;
  shut_t             shut_act;
  gen_t              gen_sh;
  gen_t              gen_act;

  scp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({ser_en_n, ser_clk, ser_data}),
    .q_out(ser_s)
  );

  scp_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(ser_s[1]), .sdat_s(ser_s[0]), .en_n_s(ser_s[2]),
    .word(word), .word_strb(word_strb), .en_rise(en_rise)
  );

  scp_shadow i_shadow (
    .clk(clk), .rst_n(rst_n),
    .word(word), .word_strb(word_strb),
    .shut_sh(shut_sh), .gen_sh(gen_sh),
    .stb_load(stb_load), .stb_new(stb_new)
  );

  scp_commit i_commit (
    .clk(clk), .rst_n(rst_n),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .readout_line(readout_line),
    .shut_sh(shut_sh), .gen_sh(gen_sh),
    .stb_load(stb_load), .stb_new(stb_new),
    .hs_commit(hs_commit), .vs_commit(vs_commit),
    .shut_act(shut_act), .gen_act(gen_act), .stb_act(act_standby)
  );

  assign act_clk_sel   = shut_act.clk_sel;
  assign act_shut_v    = shut_act.shut_v;
  assign act_shut_h    = shut_act.shut_h;
  assign act_hs_v      = shut_act.hs_v;
  assign act_mode      = gen_act.mode;
  assign act_pattern   = gen_act.pattern;
  assign act_ob_pat    = gen_act.ob_pat;
  assign act_adc_phase = gen_act.adc_phase;
  assign cam_normal    = ~act_standby[0];
endmodule

// File: rtl/scp_checker.sv
module scp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        word_strb,
  input logic        en_rise,
  input logic        hs_commit,
  input logic        vs_commit,
  input logic [1:0]  act_clk_sel,
  input logic [9:0]  act_shut_v,
  input logic [11:0] act_shut_h,
  input logic [9:0]  act_hs_v,
  input logic [1:0]  act_mode,
  input logic [1:0]  act_pattern,
  input logic [1:0]  act_ob_pat,
  input logic [1:0]  act_adc_phase,
  input logic [1:0]  act_standby,
  input logic        cam_normal
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |-> (act_shut_v == '0 && act_shut_h == '0 && act_hs_v == '0 && act_clk_sel == '0 &&
                act_mode == '0 && act_pattern == '0 && act_ob_pat == '0 && act_adc_phase == '0 &&
                act_standby == '0 && cam_normal)); // R1

  AST_FRAME_AT_ENABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    word_strb |-> $past(en_rise)); // R2

  AST_STANDBY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_standby) |-> $past(word_strb)); // R4

  AST_MODE_ON_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_mode) || !$stable(act_pattern)) |-> $past(vs_commit)); // R5

  AST_LINE_FIELDS_ON_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_shut_v) || !$stable(act_shut_h) || !$stable(act_hs_v) || !$stable(act_clk_sel) ||
     !$stable(act_ob_pat) || !$stable(act_adc_phase)) |-> $past(hs_commit)); // R6
endmodule

bind sensor_tg_serial_ctrl scp_checker i_chk (
  .clk(clk), .rst_n(rst_n), .word_strb(word_strb), .en_rise(en_rise),
  .hs_commit(hs_commit), .vs_commit(vs_commit),
  .act_clk_sel(act_clk_sel), .act_shut_v(act_shut_v), .act_shut_h(act_shut_h),
  .act_hs_v(act_hs_v), .act_mode(act_mode), .act_pattern(act_pattern),
  .act_ob_pat(act_ob_pat), .act_adc_phase(act_adc_phase),
  .act_standby(act_standby), .cam_normal(cam_normal)
);

// File: tb/test_sensor_tg_serial_ctrl.sv
module test_sensor_tg_serial_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ser_clk, ser_data, ser_en_n, hsync_n, vsync_n, readout_line;
  logic [1:0] act_clk_sel, act_mode, act_pattern, act_ob_pat, act_adc_phase, act_standby;
  logic [9:0] act_shut_v, act_hs_v;
  logic [11:0] act_shut_h;
  logic cam_normal;

  sensor_tg_serial_ctrl i_sensor_tg_serial_ctrl (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [44:0] exp_q[$];
  string tag_q[$];

  // bench model: shadows and active values
  logic [1:0] s_clk, s_mode, s_pat, s_ob, s_adph;
  logic [9:0] s_v, s_spl;
  logic [11:0] s_h;
  logic [1:0] a_clk, a_mode, a_pat, a_ob, a_adph, a_stb;
  logic [9:0] a_v, a_spl;
  logic [11:0] a_h;

  function automatic logic [44:0] dut_vec();
    return {act_clk_sel, act_shut_v, act_shut_h, act_hs_v, act_mode, act_pattern,
            act_ob_pat, act_adc_phase, act_standby, cam_normal};
  endfunction

  function automatic logic [44:0] model_vec();
    return {a_clk, a_v, a_h, a_spl, a_mode, a_pat, a_ob, a_adph, a_stb, (a_stb[0] == 1'b0)};
  endfunction

  task automatic push(input string tag);
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
  endtask

  // monitor: pops expected snapshots and compares away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [44:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (dut_vec() !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, dut_vec(), e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_clear();
    {s_clk, s_mode, s_pat, s_ob, s_adph, s_v, s_spl, s_h} = '0;
    {a_clk, a_mode, a_pat, a_ob, a_adph, a_stb, a_v, a_spl, a_h} = '0;
  endtask

  task automatic do_reset();
    ser_clk = 0; ser_data = 0; ser_en_n = 1; hsync_n = 1; vsync_n = 1; readout_line = 0;
    rst_n = 0;
    tick(3);
    model_clear();
    rst_n = 1;
    tick(2);
  endtask

  function automatic logic [63:0] shut_w(input logic [1:0] c, input logic [9:0] v,
                                         input logic [11:0] h, input logic [9:0] spl);
    logic [63:0] w = '0;
    w[7:0] = 8'h81; w[9:8] = c; w[19:10] = v; w[31:20] = h; w[41:32] = spl;
    return w;
  endfunction

  function automatic logic [63:0] gen_w(input logic [7:0] cat, input logic [1:0] m,
      input logic [1:0] p, input logic [1:0] ob, input logic [1:0] ph, input logic [1:0] sb);
    logic [63:0] w = '0;
    w[7:0] = cat; w[11:10] = m; w[17:16] = p; w[35:34] = ob; w[37:36] = ph; w[39:38] = sb;
    return w;
  endfunction

  // driver: sends n bits, first bit is word bit 0, then updates the model (R2, R3, R4)
  task automatic send(input logic [63:0] w, input int n);
    ser_en_n = 0;
    tick(4);
    for (int i = 0; i < n; i++) begin
      ser_data = w[i];
      tick(4);
      ser_clk = 1;
      tick(4);
      ser_clk = 0;
    end
    tick(4);
    ser_en_n = 1;
    tick(8);
    if (n == 48) begin
      if (w[7:0] == 8'h81) begin
        s_clk = w[9:8]; s_v = w[19:10]; s_h = w[31:20]; s_spl = w[41:32];
      end else if (w[7:0] == 8'h00) begin
        s_mode = w[11:10]; s_pat = w[17:16]; s_ob = w[35:34]; s_adph = w[37:36];
        a_stb = w[39:38];
      end
    end
  endtask

  task automatic hs_pulse(input logic ro);
    readout_line = ro;
    tick(2);
    hsync_n = 0;
    tick(3);
    hsync_n = 1;
    tick(3);
    readout_line = 0;
    if (ro) begin
      a_clk = s_clk; a_v = s_v; a_h = s_h; a_spl = s_spl; a_ob = s_ob; a_adph = s_adph;
    end
  endtask

  task automatic vs_pulse();
    tick(2);
    vsync_n = 0;
    tick(3);
    vsync_n = 1;
    tick(3);
    a_mode = s_mode; a_pat = s_pat;
  endtask

  initial begin
    do_reset();
    push("R1 reset state");

    send(shut_w(2'd2, 10'h155, 12'hA5C, 10'h2F3), 48);
    push("R6 shutter word waits in shadow");
    hs_pulse(1'b0);
    push("R6 hsync outside readout ignored");
    hs_pulse(1'b1);
    push("R3 shutter fields committed at readout hsync");
    vs_pulse();
    push("R5 vsync leaves shutter fields alone");

    send(gen_w(8'h00, 2'd3, 2'd2, 2'd1, 2'd3, 2'b01), 48);
    push("R4 standby applied at enable rise, R7 cam_normal low");
    vs_pulse();
    push("R5 mode and pattern at vsync");
    hs_pulse(1'b1);
    push("R6 ob pattern and converter phase at hsync");

    send(shut_w(2'd1, 10'h0AA, 12'h123, 10'h011), 40);
    hs_pulse(1'b1);
    push("R2 short frame dropped");
    send(gen_w(8'h00, 2'd1, 2'd1, 2'd2, 2'd2, 2'b00) | 64'h1_0000_0000_0000, 49);
    vs_pulse();
    hs_pulse(1'b1);
    push("R2 long frame dropped");

    send(gen_w(8'h42, 2'd0, 2'd3, 2'd0, 2'd1, 2'b11), 48);
    vs_pulse();
    hs_pulse(1'b1);
    push("R3 unknown category ignored");

    send(gen_w(8'h00, 2'd1, 2'd1, 2'd2, 2'd2, 2'b10), 48);
    push("R7 bit38 zero means normal operation");

    send(shut_w(2'd3, 10'h3FF, 12'hFFF, 10'h3FF), 48);
    send(shut_w(2'd1, 10'h201, 12'h804, 10'h102), 48);
    hs_pulse(1'b1);
    push("R8 last shutter word committed");

    send(gen_w(8'h00, 2'd2, 2'd3, 2'd3, 2'd1, 2'b01), 48);
    send(gen_w(8'h00, 2'd0, 2'd2, 2'd1, 2'd0, 2'b11), 48);
    vs_pulse();
    push("R8 last general word at vsync");

    send(shut_w(2'd2, 10'h0F0, 12'h0F0, 10'h0F0), 48);
    do_reset();
    push("R1 reset mid-run");
    hs_pulse(1'b1);
    vs_pulse();
    push("R1 shadows cleared by reset");

    tick(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule